// File: doc/BRIEF.md
# PWM Output Compare Channel

This block is a single compare channel that sits beside a timer's time-base. Each clock it compares the time-base count with a shadow compare value and forms a reference waveform. In the first PWM mode the waveform is high during the early part of the period. The second PWM mode gives the inverted waveform. A polarity choice and an enable bit then give the pin-level channel output. A sticky flag records that the count reached the compare value. In center-aligned operation the alignment selector can restrict the flag to one counting direction.

Software writes the compare value through a write strobe. With preload off, the value goes straight into the shadow register. With preload on, it waits in a preload register until the time-base issues an update pulse. Two edge cases are defined. A compare value above the reload value pins the first-mode reference high. A zero compare value that follows a period whose compare value was at or above reload raises no compare event at count zero, and the reference stays low there.

Top module: `pwm_cmp_chan`

## Requirements
- R1: After reset, chOut, refOut and cmpFlag are 0, and the mode field is 3'b000.
- R2: With mode 3'b110 and cntDown=0, refOut is 1 exactly when cnt < shadow, one clock after cnt is presented. A shadow of 0 gives 0. A shadow above reloadVal gives 1 for every cnt <= reloadVal.
- R3: With mode 3'b110 and cntDown=1, refOut is 1 exactly when cnt <= shadow, with the same one-clock latency.
- R4: Mode 3'b111 gives the logical inverse of the mode 3'b110 reference for the same cnt, direction and shadow.
- R5: Any mode value other than 3'b110 or 3'b111 holds refOut at 0.
- R6: With cfgPreload=0, a cmpWr loads the shadow at once. With cfgPreload=1, the written value waits and reaches the shadow only on the next updEvt; until then the old shadow keeps deciding refOut.
- R7: With cfgChanEn=1, chOut = refOut XOR activeLow. With cfgChanEn=0, chOut equals the activeLow bit, which is the inactive level.
- R8: With alignSel 2'b00 or 2'b11, cmpFlag becomes 1 one clock after a cycle with tickEn=1 and cnt == shadow, in either direction. A cycle with tickEn=0 or cnt != shadow does not set it.
- R9: With alignSel 2'b01, a match sets the flag only when cntDown=1. With alignSel 2'b10, it sets the flag only when cntDown=0.
- R10: cmpFlag stays 1 until a flagClr pulse clears it on the next clock. When a set and a flagClr fall in the same cycle, the set wins.
- R11: Each updEvt records whether the outgoing shadow was >= reloadVal. If that record is set and the shadow is now 0, then at cnt=0 no flag is raised and the mode 3'b110 reference is 0 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cnt | input | CNT_W | Time-base count |
| cntDown | input | 1 | Time-base counting down |
| tickEn | input | 1 | Count is valid this cycle; enables the flag |
| updEvt | input | 1 | Time-base update pulse |
| reloadVal | input | CNT_W | Time-base reload value |
| alignSel | input | 2 | Alignment selector (00 edge, 01/10/11 center) |
| cfgWr | input | 1 | Configuration write strobe |
| cfgMode | input | 3 | Output mode field |
| cfgPreload | input | 1 | Compare preload enable |
| cfgActiveLow | input | 1 | Output polarity (1 = active low) |
| cfgChanEn | input | 1 | Channel output enable |
| cmpWr | input | 1 | Compare value write strobe |
| cmpData | input | CNT_W | Compare value written |
| flagClr | input | 1 | Write-one-to-clear pulse for the flag |
| chOut | output | 1 | Polarity-adjusted channel output |
| refOut | output | 1 | Raw reference waveform |
| cmpFlag | output | 1 | Sticky compare flag |

## Verification
refOut and cmpFlag are registered, so each is due one clock after the cnt, direction and tickEn that produce it. chOut follows refOut and the configuration registers in the same cycle. A configuration write or a direct compare write takes effect at one edge and first shapes refOut at the next edge. A preloaded value reaches refOut only one edge after the updEvt that moves it into the shadow. The bench drives every input on a falling edge and samples one full period later, after exactly one rising edge. Where the same write or update also moves the shadow, it waits one extra idle cycle.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam logic [2:0] MODE_PWM1 = 3'b110;
  localparam logic [2:0] MODE_PWM2 = 3'b111;

  typedef struct packed {
    logic [2:0] mode;
    logic       preloadEn;
    logic       activeLow;
    logic       chanEn;
  } chanCfg_t;

  typedef struct packed {
    logic preloadLoad;
    logic shadowFromBus;
    logic shadowFromPre;
    logic periodMark;
  } cmpStrobe_t;
endpackage

// File: rtl/pwm_cmp_dp.sv
module pwm_cmp_dp
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanCfg_t         cfg,
  input  cmpStrobe_t       strobe,
  input  logic [CNT_W-1:0] cmpData,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cntDown,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             atMatch,
  output logic             refOut
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] preVal;
  logic [CNT_W-1:0] shadowVal;
  logic             prevHigh;
  logic             refReg;
  logic             suppress;
  logic             baseRef;
  logic             mode1Ref;
  logic             refNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preVal    <= '0;
      shadowVal <= '0;
      prevHigh  <= 1'b0;
    end else begin
      if (strobe.preloadLoad) preVal <= cmpData;
      if (strobe.shadowFromBus)      shadowVal <= cmpData;
      else if (strobe.shadowFromPre) shadowVal <= preVal;
      if (strobe.periodMark) prevHigh <= (shadowVal >= reloadVal);
    end
  end

  always_comb begin
    suppress = prevHigh && (shadowVal == ZERO) && (cnt == ZERO);
    baseRef  = cntDown ? (cnt <= shadowVal) : (cnt < shadowVal);
    mode1Ref = baseRef && !suppress;
    atMatch  = (cnt == shadowVal) && !suppress;
    case (cfg.mode)
      MODE_PWM1: refNext = mode1Ref;
      MODE_PWM2: refNext = !mode1Ref;
      default:   refNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) refReg <= 1'b0;
    else       refReg <= refNext;
  end

  assign refOut = refReg;

  // R6
  preload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.preloadEn && !strobe.shadowFromPre) |=> $stable(shadowVal));

  // R2
  zero_cmp_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_PWM1 && !cntDown && shadowVal == ZERO) |=> !refReg);

  // R2
  above_reload_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_PWM1 && shadowVal > reloadVal && cnt <= reloadVal) |=> refReg);

  // R11
  wrap_suppress_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_PWM1 && prevHigh && shadowVal == ZERO && cnt == ZERO) |=> !refReg);

  // R5
  other_mode_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode != MODE_PWM1 && cfg.mode != MODE_PWM2) |=> !refReg);
endmodule

// File: rtl/pwm_cmp_ctrl.sv
module pwm_cmp_ctrl
  import pwm_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic [2:0] cfgMode,
  input  logic       cfgPreload,
  input  logic       cfgActiveLow,
  input  logic       cfgChanEn,
  input  logic       cmpWr,
  input  logic       updEvt,
  input  logic       tickEn,
  input  logic       cntDown,
  input  logic [1:0] alignSel,
  input  logic       flagClr,
  input  logic       atMatch,
  output chanCfg_t   cfg,
  output cmpStrobe_t strobe,
  output logic       cmpFlag
);
  logic dirOk;
  logic setNow;
  logic flagReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (cfgWr) begin
      cfg.mode      <= cfgMode;
      cfg.preloadEn <= cfgPreload;
      cfg.activeLow <= cfgActiveLow;
      cfg.chanEn    <= cfgChanEn;
    end
  end

  always_comb begin
    strobe.preloadLoad   = cmpWr;
    strobe.shadowFromBus = cmpWr && !cfg.preloadEn;
    strobe.shadowFromPre = updEvt && cfg.preloadEn;
    strobe.periodMark    = updEvt;
    case (alignSel)
      2'b01:   dirOk = cntDown;
      2'b10:   dirOk = !cntDown;
      default: dirOk = 1'b1;
    endcase
    setNow = tickEn && atMatch && dirOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        flagReg <= 1'b0;
    else if (setNow)  flagReg <= 1'b1;
    else if (flagClr) flagReg <= 1'b0;
  end

  assign cmpFlag = flagReg;

  // R8
  both_dir_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && atMatch && (alignSel == 2'b00 || alignSel == 2'b11)) |=> flagReg);

  // R9
  down_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alignSel == 2'b01 && !cntDown && !flagReg && !flagClr) |=> !flagReg);

  // R9
  up_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alignSel == 2'b10 && cntDown && !flagReg && !flagClr) |=> !flagReg);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg && !flagClr) |=> flagReg);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !tickEn) |=> !flagReg);
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cntDown,
  input  logic             tickEn,
  input  logic             updEvt,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [1:0]       alignSel,
  input  logic             cfgWr,
  input  logic [2:0]       cfgMode,
  input  logic             cfgPreload,
  input  logic             cfgActiveLow,
  input  logic             cfgChanEn,
  input  logic             cmpWr,
  input  logic [CNT_W-1:0] cmpData,
  input  logic             flagClr,
  output logic             chOut,
  output logic             refOut,
  output logic             cmpFlag
);
  chanCfg_t   cfg;
  cmpStrobe_t strobe;
  logic       atMatch;

  pwm_cmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMode(cfgMode),
    .cfgPreload(cfgPreload), .cfgActiveLow(cfgActiveLow), .cfgChanEn(cfgChanEn),
    .cmpWr(cmpWr), .updEvt(updEvt), .tickEn(tickEn), .cntDown(cntDown),
    .alignSel(alignSel), .flagClr(flagClr), .atMatch(atMatch),
    .cfg(cfg), .strobe(strobe), .cmpFlag(cmpFlag)
  );

  pwm_cmp_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe), .cmpData(cmpData),
    .cnt(cnt), .cntDown(cntDown), .reloadVal(reloadVal),
    .atMatch(atMatch), .refOut(refOut)
  );

  assign chOut = cfg.chanEn ? (refOut ^ cfg.activeLow) : cfg.activeLow;

  // R7
  disabled_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWr && !cfg.chanEn) |=> (chOut == $past(cfg.activeLow)));
endmodule

// File: tb/pwm_cmp_chan_test.sv
module pwm_cmp_chan_test;
  localparam int W = 4;
  localparam logic [W-1:0] RELOAD = 4'd10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] cnt = '0;
  logic cntDown = 1'b0, tickEn = 1'b0, updEvt = 1'b0;
  logic [1:0] alignSel = 2'b00;
  logic cfgWr = 1'b0, cfgPreload = 1'b0, cfgActiveLow = 1'b0, cfgChanEn = 1'b0;
  logic [2:0] cfgMode = 3'b000;
  logic cmpWr = 1'b0, flagClr = 1'b0;
  logic [W-1:0] cmpData = '0;
  logic chOut, refOut, cmpFlag;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwm_cmp_chan #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .cnt(cnt), .cntDown(cntDown), .tickEn(tickEn),
    .updEvt(updEvt), .reloadVal(RELOAD), .alignSel(alignSel), .cfgWr(cfgWr),
    .cfgMode(cfgMode), .cfgPreload(cfgPreload), .cfgActiveLow(cfgActiveLow),
    .cfgChanEn(cfgChanEn), .cmpWr(cmpWr), .cmpData(cmpData), .flagClr(flagClr),
    .chOut(chOut), .refOut(refOut), .cmpFlag(cmpFlag)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfgSet(logic [2:0] m, logic pre, logic pol, logic en);
    cfgMode = m; cfgPreload = pre; cfgActiveLow = pol; cfgChanEn = en; cfgWr = 1'b1;
    @(negedge clk); cfgWr = 1'b0;
  endtask

  task automatic cmpSet(logic [W-1:0] v);
    cmpData = v; cmpWr = 1'b1;
    @(negedge clk); cmpWr = 1'b0;
  endtask

  task automatic updPulse();
    updEvt = 1'b1;
    @(negedge clk); updEvt = 1'b0;
  endtask

  task automatic flagClear();
    tickEn = 1'b0; flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  function automatic logic model(logic [2:0] m, logic d, int c, int n);
    logic r;
    r = d ? (n <= c) : (n < c);
    if (m == 3'b110) return r;
    if (m == 3'b111) return !r;
    return 1'b0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 chOut", chOut, 1'b0);
    chk("R1 refOut", refOut, 1'b0);
    chk("R1 cmpFlag", cmpFlag, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 refOut after release", refOut, 1'b0);

    // R2 R3 R4 R5 exhaustive sweep, direct compare loads
    for (int mi = 0; mi < 3; mi++) begin
      logic [2:0] m;
      m = (mi == 0) ? 3'b110 : (mi == 1) ? 3'b111 : 3'b000;
      cfgSet(m, 1'b0, 1'b0, 1'b1);
      for (int d = 0; d < 2; d++) begin
        for (int c = 0; c < 16; c++) begin
          cmpSet(c[W-1:0]);
          for (int n = 0; n < 16; n++) begin
            cnt = n[W-1:0]; cntDown = d[0];
            @(negedge clk);
            chk(mi == 2 ? "R5 ref" : (mi == 1 ? "R4 ref" : (d == 0 ? "R2 ref" : "R3 ref")),
                refOut, model(m, d[0], c, n));
            chk("R7 chOut enabled", chOut, model(m, d[0], c, n));
          end
        end
      end
    end

    // R7 polarity and enable
    cfgSet(3'b110, 1'b0, 1'b0, 1'b1);
    cmpSet(4'd8);
    cntDown = 1'b0;
    for (int p = 0; p < 2; p++) begin
      for (int e = 0; e < 2; e++) begin
        cfgSet(3'b110, 1'b0, p[0], e[0]);
        cnt = 4'd3; @(negedge clk);
        chk("R7 out ref1", chOut, e[0] ? !p[0] : p[0]);
        cnt = 4'd12; @(negedge clk);
        chk("R7 out ref0", chOut, e[0] ? p[0] : p[0]);
      end
    end
    cfgSet(3'b110, 1'b0, 1'b0, 1'b1);

    // R8 R9 flag qualification sweep, shadow 6
    cmpSet(4'd6);
    for (int a = 0; a < 4; a++) begin
      for (int d = 0; d < 2; d++) begin
        alignSel = a[1:0]; cntDown = d[0];
        flagClear();
        cnt = 4'd6; tickEn = 1'b1; @(negedge clk); tickEn = 1'b0;
        chk((a == 1 || a == 2) ? "R9 flag on match" : "R8 flag on match", cmpFlag,
            (a == 1) ? d[0] : (a == 2) ? !d[0] : 1'b1);
        flagClear();
        cnt = 4'd7; tickEn = 1'b1; @(negedge clk); tickEn = 1'b0;
        chk("R8 no flag off match", cmpFlag, 1'b0);
        cnt = 4'd6; @(negedge clk);
        chk("R8 no flag without tick", cmpFlag, 1'b0);
      end
    end

    // R10 sticky, clear, set wins
    alignSel = 2'b00; cntDown = 1'b0;
    cnt = 4'd6; tickEn = 1'b1; @(negedge clk); tickEn = 1'b0;
    cnt = 4'd1; repeat (3) @(negedge clk);
    chk("R10 sticky", cmpFlag, 1'b1);
    flagClear();
    chk("R10 cleared", cmpFlag, 1'b0);
    cnt = 4'd6; tickEn = 1'b1; flagClr = 1'b1; @(negedge clk);
    tickEn = 1'b0; flagClr = 1'b0;
    chk("R10 set wins", cmpFlag, 1'b1);
    flagClear();

    // R6 preload
    cmpSet(4'd9);
    cfgSet(3'b110, 1'b1, 1'b0, 1'b1);
    cmpSet(4'd5);
    cnt = 4'd7; cntDown = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 old shadow held", refOut, 1'b1);
    updPulse();
    @(negedge clk);
    chk("R6 new shadow after update", refOut, 1'b0);

    // R11 wrap suppression
    cmpSet(4'd15); updPulse();
    cmpSet(4'd0);  updPulse();
    flagClear();
    cnt = 4'd0; cntDown = 1'b1; alignSel = 2'b00; tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    chk("R11 ref low at zero", refOut, 1'b0);
    chk("R11 no flag at zero", cmpFlag, 1'b0);
    updPulse();
    tickEn = 1'b1; @(negedge clk); tickEn = 1'b0;
    chk("R11 ref back after clean period", refOut, 1'b1);
    chk("R11 flag back after clean period", cmpFlag, 1'b1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule